// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the master side of an external bus where the address and the data share one set of 16 data lines, for one chip-select region. An internal client hands it one access at a time through a valid/ready request port. Each request carries a direction, an address and write data. The controller then runs the external cycle: an address phase that puts the low address bits onto the data lines, then an ordinary data phase with a read or write strobe.

The address phase always opens with one cycle in which the data lines float. Because of this, a new access can follow the previous data phase with no idle cycle, and the bus still sees no contention. One configuration input stretches the address drive from one cycle to two. Another sets the number of wait cycles in the data phase. A third picks the bus width: fixed 8 bits, fixed 16 bits, or chosen per access by the top address bit. All configuration is captured when a request is accepted.

Back-pressure: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle or in the last cycle of a data phase. A client that sees `req_ready` low keeps its request fields steady and keeps `req_valid` high. Completion is a one-cycle `rsp_valid` pulse with no back-pressure.

Top module: `mxbus_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, `bus_cs_n`, `bus_ah_n` and `bus_rd_n` are 1, `bus_wr_n` is 2'b11, `bus_data_oe` is 2'b00, `rsp_valid` is 0 and `req_ready` is 1.
- R2: In the first cycle of every access, `bus_cs_n` is 0, `bus_ah_n` is 1 and `bus_data_oe` is 2'b00, so the data lines float.
- R3: After that first cycle, the address is driven for exactly one cycle when `cfg_addr_long` is 0 and for two cycles when it is 1. In those cycles `bus_ah_n` is 0 and `bus_data_o` carries the address bits [15:0] (16-bit) or [7:0] on lines [7:0] (8-bit).
- R4: `cfg_width_mode` 2'b00 selects 8-bit and 2'b01 selects 16-bit. 2'b10 or 2'b11 selects 16-bit when `req_addr[AW-1]` is 1 and 8-bit otherwise. An 8-bit access enables only lane 0 (`bus_data_oe`=2'b01), and a 16-bit access enables both lanes (2'b11).
- R5: While `bus_cs_n` is 0, `bus_rdwr` is 1 for a read and 0 for a write. It takes that value in the same cycle as chip select asserts.
- R6: The data phase lasts `cfg_wait`+1 cycles with `bus_ah_n` at 1. A read holds `bus_rd_n` at 0 and `bus_data_oe` at 2'b00 for the whole phase. Strobes are 1 at all other times.
- R7: A write holds `bus_wr_n` low on the enabled lanes for the whole data phase (2'b10 for 8-bit, 2'b00 for 16-bit). It drives the write data (low byte only for 8-bit) with those lanes enabled.
- R8: Read data is sampled from `bus_data_i` at the end of the last data cycle. It is presented on `rsp_rdata` with a one-cycle `rsp_valid` pulse in the next cycle, with the upper byte 0 for 8-bit reads. A write also ends with a `rsp_valid` pulse.
- R9: `req_ready` is 0 from the first access cycle until the last data cycle. A request held during that time is accepted at the last data cycle. It then starts the next cycle with `bus_cs_n` still 0 and no idle cycle.
- R10: Changing the configuration inputs during an access does not change that access; the values present at acceptance apply.
- R11: `bus_cs_n` stays 0 without a break from the first access cycle to the end of the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| cfg_addr_long | input | 1 | 1 = two address-drive cycles |
| cfg_wait | input | 3 | Data-phase wait cycles |
| cfg_width_mode | input | 2 | Bus width selection |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ah_n | output | 1 | Address hold, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 2 | Write strobe per byte lane, active low |
| bus_rdwr | output | 1 | Direction: 1 read, 0 write |
| bus_data_o | output | 16 | Data lines, outgoing value |
| bus_data_oe | output | 2 | Output enable per byte lane |
| bus_data_i | input | 16 | Data lines, incoming value |

## Verification
Single reads and writes are run with both address lengths, several wait counts and all three width modes. Each cycle is compared against the expected phase, so a wrong phase length, a missing float cycle or a wrong lane enable shows up in the cycle where it happens. The read data on the lines is wrong in every cycle except the last data cycle, which tells sampling at the end apart from sampling early. A chained pair with a request held high and the configuration changed mid-access separates proper stalling, gap-free hand-over and capture of configuration at acceptance.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  localparam int DW    = 16;
  localparam int WAITW = 3;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR_Z,
    PH_ADDR_DRV,
    PH_DATA
  } phase_e;

  typedef struct packed {
    logic             write;
    logic             wide;
    logic             addr_long;
    logic [WAITW-1:0] wait_n;
    logic [DW-1:0]    addr_lo;
    logic [DW-1:0]    wdata;
  } access_t;
endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic                cfg_addr_long,
  input  logic [WAITW-1:0]    cfg_wait,
  input  logic [1:0]          cfg_width_mode,
  output phase_e              phase,
  output access_t             acc,
  output logic                last_data
);
  logic [WAITW-1:0] cnt;
  logic             wide_sel;
  logic             accept;
  access_t          nxt_acc;
  logic             addr_unused;

  assign addr_unused = ^req_addr;

  always_comb begin
    case (cfg_width_mode)
      2'b00:   wide_sel = 1'b0;
      2'b01:   wide_sel = 1'b1;
      default: wide_sel = req_addr[AW-1];
    endcase
  end

  assign last_data = (phase == PH_DATA) && (cnt == '0);
  assign req_ready = (phase == PH_IDLE) || last_data;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt_acc.write     = req_write;
    nxt_acc.wide      = wide_sel;
    nxt_acc.addr_long = cfg_addr_long;
    nxt_acc.wait_n    = cfg_wait;
    nxt_acc.addr_lo   = req_addr[DW-1:0];
    nxt_acc.wdata     = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      acc   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            acc   <= nxt_acc;
            phase <= PH_ADDR_Z;
          end
        end
        PH_ADDR_Z: begin
          phase <= PH_ADDR_DRV;
          cnt   <= acc.addr_long ? WAITW'(1) : '0;
        end
        PH_ADDR_DRV: begin
          if (cnt == '0) begin
            phase <= PH_DATA;
            cnt   <= acc.wait_n;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            if (accept) begin
              acc   <= nxt_acc;
              phase <= PH_ADDR_Z;
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assert_float_then_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_ADDR_Z |=> phase == PH_ADDR_DRV);

  assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> phase == PH_ADDR_Z);

  assert_drive_leads_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) != PH_DATA) |-> $past(phase) == PH_ADDR_DRV);
endmodule

// File: rtl/mxbus_pins.sv
module mxbus_pins
  import mxbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  access_t       acc,
  output logic          bus_cs_n,
  output logic          bus_ah_n,
  output logic          bus_rd_n,
  output logic [1:0]    bus_wr_n,
  output logic          bus_rdwr,
  output logic [DW-1:0] bus_data_o,
  output logic [1:0]    bus_data_oe
);
  logic [1:0]    lanes;
  logic [DW-1:0] lane_mask;

  assign lanes     = acc.wide ? 2'b11 : 2'b01;
  assign lane_mask = acc.wide ? {DW{1'b1}} : {{(DW/2){1'b0}}, {(DW/2){1'b1}}};

  always_comb begin
    bus_cs_n    = 1'b1;
    bus_ah_n    = 1'b1;
    bus_rd_n    = 1'b1;
    bus_wr_n    = 2'b11;
    bus_rdwr    = 1'b1;
    bus_data_o  = '0;
    bus_data_oe = 2'b00;
    if (phase != PH_IDLE) begin
      bus_cs_n = 1'b0;
      bus_rdwr = ~acc.write;
    end
    case (phase)
      PH_ADDR_DRV: begin
        bus_ah_n    = 1'b0;
        bus_data_o  = acc.addr_lo & lane_mask;
        bus_data_oe = lanes;
      end
      PH_DATA: begin
        if (acc.write) begin
          bus_wr_n    = ~lanes;
          bus_data_o  = acc.wdata & lane_mask;
          bus_data_oe = lanes;
        end else begin
          bus_rd_n = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> (bus_ah_n && bus_rd_n && bus_wr_n == 2'b11 && bus_data_oe == 2'b00));

  assert_first_cycle_floats_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> (bus_data_oe == 2'b00 && bus_ah_n));

  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (bus_data_oe == 2'b00 && bus_wr_n == 2'b11 && bus_ah_n));

  assert_cs_through_address_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ah_n |=> !bus_cs_n);
endmodule

// File: rtl/mxbus_capture.sv
module mxbus_capture
  import mxbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          last_data,
  input  logic          acc_write,
  input  logic          acc_wide,
  input  logic [DW-1:0] bus_data_i,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= last_data;
      if (last_data && !acc_write) begin
        rsp_rdata <= acc_wide ? bus_data_i : {{(DW/2){1'b0}}, bus_data_i[DW/2-1:0]};
      end
    end
  end

  assert_done_is_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
  import mxbus_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  input  logic          cfg_addr_long,
  input  logic [2:0]    cfg_wait,
  input  logic [1:0]    cfg_width_mode,
  output logic          bus_cs_n,
  output logic          bus_ah_n,
  output logic          bus_rd_n,
  output logic [1:0]    bus_wr_n,
  output logic          bus_rdwr,
  output logic [15:0]   bus_data_o,
  output logic [1:0]    bus_data_oe,
  input  logic [15:0]   bus_data_i
);
  phase_e  phase;
  access_t acc;
  logic    last_data;

  mxbus_seq #(.AW(AW)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .cfg_addr_long  (cfg_addr_long),
    .cfg_wait       (cfg_wait),
    .cfg_width_mode (cfg_width_mode),
    .phase          (phase),
    .acc            (acc),
    .last_data      (last_data)
  );

  mxbus_pins u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .acc         (acc),
    .bus_cs_n    (bus_cs_n),
    .bus_ah_n    (bus_ah_n),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_rdwr    (bus_rdwr),
    .bus_data_o  (bus_data_o),
    .bus_data_oe (bus_data_oe)
  );

  mxbus_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_data  (last_data),
    .acc_write  (acc.write),
    .acc_wide   (acc.wide),
    .bus_data_i (bus_data_i),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assert_dir_with_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n[0]) |-> (!bus_rdwr && !bus_cs_n));
endmodule

// File: tb/mxbus_ctrl_bench.sv
module mxbus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          cfg_addr_long = 1'b0;
  logic [2:0]    cfg_wait = '0;
  logic [1:0]    cfg_width_mode = '0;
  logic          bus_cs_n, bus_ah_n, bus_rd_n, bus_rdwr;
  logic [1:0]    bus_wr_n, bus_data_oe;
  logic [15:0]   bus_data_o;
  logic [15:0]   bus_data_i = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxbus_ctrl #(.AW(AW)) u_mxbus_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_addr_long(cfg_addr_long), .cfg_wait(cfg_wait), .cfg_width_mode(cfg_width_mode),
    .bus_cs_n(bus_cs_n), .bus_ah_n(bus_ah_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_rdwr(bus_rdwr), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_data_i(bus_data_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(bus_cs_n && bus_ah_n && bus_rd_n && bus_wr_n == 2'b11 && bus_data_oe == 2'b00,
        {"R1 idle pins ", tag}, {bus_cs_n, bus_ah_n, bus_rd_n, bus_wr_n, bus_data_oe}, 7'b1111100);
    chk(req_ready == 1'b1, {"R1 ready ", tag}, req_ready, 1);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk_idle("after reset");
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
  endtask

  // one isolated access, checked cycle by cycle (R2..R8, R11)
  task automatic run_access(input bit wr, input logic [AW-1:0] addr, input logic [15:0] wd,
                            input bit a_long, input logic [2:0] w, input logic [1:0] mode,
                            input logic [15:0] rd_val);
    bit wide;
    int nad, total;
    logic [15:0] mask;
    logic [1:0] eoe;
    wide  = (mode == 2'b00) ? 1'b0 : (mode == 2'b01) ? 1'b1 : addr[AW-1];
    nad   = a_long ? 2 : 1;
    total = 1 + nad + int'(w) + 1;
    mask  = wide ? 16'hFFFF : 16'h00FF;
    eoe   = wide ? 2'b11 : 2'b01;
    @(negedge clk);
    cfg_addr_long = a_long; cfg_wait = w; cfg_width_mode = mode;
    req_write = wr; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    bus_data_i = ~rd_val;
    @(posedge clk);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_cs_n == 1'b0, "R11 cs held low", bus_cs_n, 0);
      chk(bus_rdwr == !wr, "R5 rdwr level", bus_rdwr, !wr);
      chk(req_ready == (k == total - 1), "R9 ready only at last data", req_ready, k == total - 1);
      if (k == 0) begin
        chk(bus_data_oe == 2'b00 && bus_ah_n, "R2 first cycle floats", {bus_ah_n, bus_data_oe}, 3'b100);
      end else if (k <= nad) begin
        chk(bus_ah_n == 1'b0, "R3 ah asserted", bus_ah_n, 0);
        chk(bus_data_oe == eoe, "R4 address lanes", bus_data_oe, eoe);
        chk((bus_data_o & mask) == (addr[15:0] & mask), "R3 address on lines",
            bus_data_o & mask, addr[15:0] & mask);
      end else begin
        chk(bus_ah_n == 1'b1, "R6 ah negated in data", bus_ah_n, 1);
        chk(bus_rd_n == wr, "R6 read strobe", bus_rd_n, wr);
        if (wr) begin
          chk(bus_wr_n == ~eoe, "R7 write strobe lanes", bus_wr_n, ~eoe);
          chk(bus_data_oe == eoe, "R7 write lanes enabled", bus_data_oe, eoe);
          chk((bus_data_o & mask) == (wd & mask), "R7 write data", bus_data_o & mask, wd & mask);
        end else begin
          chk(bus_wr_n == 2'b11 && bus_data_oe == 2'b00, "R6 read leaves lines free",
              {bus_wr_n, bus_data_oe}, 4'b1100);
        end
      end
      bus_data_i = (k == total - 1) ? rd_val : ~rd_val;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R8 done pulse", rsp_valid, 1);
    if (!wr) chk(rsp_rdata == (rd_val & mask), "R8 read data", rsp_rdata, rd_val & mask);
    chk_idle("after access");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 done is one cycle", rsp_valid, 0);
  endtask

  task automatic test_singles();
    run_access(1'b1, 24'h00BEEF, 16'hC3A5, 1'b0, 3'd0, 2'b01, 16'h0000);
    run_access(1'b0, 24'h001357, 16'h0000, 1'b0, 3'd3, 2'b01, 16'h9A7E);
    run_access(1'b0, 24'h002468, 16'h0000, 1'b1, 3'd1, 2'b00, 16'h1234);
    run_access(1'b1, 24'h0055AA, 16'hF00D, 1'b1, 3'd7, 2'b00, 16'h0000);
  endtask

  task automatic test_width_by_address();
    // R4: mode 2'b10 follows req_addr[AW-1]
    run_access(1'b0, 24'h80ABCD, 16'h0000, 1'b0, 3'd2, 2'b10, 16'h6B4C);
    run_access(1'b1, 24'h00ABCD, 16'h7788, 1'b0, 3'd1, 2'b11, 16'h0000);
    run_access(1'b1, 24'h80FEDC, 16'h7788, 1'b1, 3'd0, 2'b11, 16'h0000);
  endtask

  // R9 stall and gap-free chaining, R10 config captured at acceptance
  task automatic test_chain();
    @(negedge clk);
    cfg_addr_long = 1'b0; cfg_wait = 3'd0; cfg_width_mode = 2'b01;
    req_write = 1'b1; req_addr = 24'h001234; req_wdata = 16'hA5A5; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b0; req_addr = 24'h000042; cfg_wait = 3'd2;
    chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 ready low in address", req_ready, 0);
    chk(bus_data_o == 16'h1234 && !bus_ah_n, "R3 chained address", bus_data_o, 16'h1234);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 wait captured at accept", req_ready, 1);
    chk(bus_wr_n == 2'b00 && bus_data_o == 16'hA5A5, "R7 chained write data", bus_data_o, 16'hA5A5);
    bus_data_i = 16'h0000;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_cs_n == 1'b0, "R9 no idle between accesses", bus_cs_n, 0);
    chk(bus_data_oe == 2'b00 && bus_ah_n, "R2 chained first cycle floats", bus_data_oe, 0);
    chk(bus_rdwr == 1'b1, "R5 rdwr flips for read", bus_rdwr, 1);
    chk(rsp_valid == 1'b1, "R8 first access done", rsp_valid, 1);
    @(negedge clk);
    chk(bus_data_o == 16'h0042, "R3 second address", bus_data_o, 16'h0042);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk(bus_rd_n == 1'b0, "R6 read strobe chained", bus_rd_n, 0);
      chk(req_ready == (k == 4), "R10 new wait applied", req_ready, k == 4);
      bus_data_i = (k == 4) ? 16'h5AC3 : 16'h0000;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_rdata == 16'h5AC3, "R8 chained read data", rsp_rdata, 16'h5AC3);
    chk_idle("after chain");
    cfg_wait = 3'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_singles();
    test_width_by_address();
    test_chain();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule